// File: doc/BRIEF.md
# Machine-Check Error Bank Logger

The logger keeps a small set of error banks. Each bank holds a control word, a status word, an address word and an auxiliary word. A single global status word sits beside them. Error reports arrive on a one-cycle strobe. Each report names a bank and carries a status, a global status, an address, an auxiliary value and an unconditional flag. The logger decides whether the report is stored, ignored, dropped or escalated. It then updates the named bank and returns a 2-bit result code one cycle later. When an uncorrected error is stored, the logger also emits an interrupt pulse. When the error cannot be handled, it emits a reset request pulse instead.

The decision depends on three configuration inputs and on the current contents of the target bank. The configuration inputs are the enabled bank count with a global-control presence flag, the global control word, and a machine-check enable. An uncorrected entry in a bank is protected from being overwritten by later corrected errors; such an error only marks overflow. A small write port lets the owner of the block set the control words, the status words and the global status, for example to clear the in-progress bit. A registered read port returns one bank's contents.

Status layout used throughout: bit 63 valid, bit 62 overflow, bit 61 uncorrected, bit 55 action required. Global status bit 2 means a check is in progress.

Top module: `mcb_logger`

## Requirements
- R1: A report is dropped with code 2 and changes nothing if its bank is not below `cap_banks`, if its bank is not below the number of implemented banks, or if its status bit 63 is clear.
- R2: An accepted report with bit 55 clear, arriving while global status bit 2 is set and with `rep_uncond` low, is ignored with code 1 and changes nothing.
- R3: A report with bit 61 set is dropped with code 2 and changes nothing if `cap_gctl_p` is high and `gctl` is not all ones, or if the bank's control word is not all ones.
- R4: Otherwise, an uncorrected report gives code 3 and a one-cycle `reset_req` pulse, and changes nothing, when `mce_en` is low or global status bit 2 is set.
- R5: Otherwise, an uncorrected report is logged with code 0. The bank status becomes the reported status with bit 62 also set if the bank was already valid. Address, auxiliary word and global status take the reported values, and `mce_irq` pulses once.
- R6: A corrected report (bit 61 clear) to a bank that is empty or holds a corrected entry is logged with code 0. Status, address and auxiliary word are replaced, and bit 62 is set if the bank was valid. Global status is kept and no interrupt is raised.
- R7: A corrected report to a bank holding a valid uncorrected entry only sets bit 62 of that bank's status (code 0). Address, auxiliary word and the rest of the status stay unchanged.
- R8: `res_valid` is high exactly in the cycle after each `rep_valid` cycle, with `res_code` meaning 0 logged, 1 ignored, 2 dropped, 3 reset. `mce_irq` and `reset_req` are high only together with code 0 and code 3 respectively.
- R9: The write port selects by `wr_target`: 0 bank control, 1 bank status, 2 global status, 3 nothing. A write in a cycle with `rep_valid` high is discarded. The read port returns a bank's words one cycle after `rd_bank` is presented.
- R10: After reset all bank status words and the global status are zero, all control words are all ones, and no result, interrupt or reset request is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_banks | input | 8 | Enabled bank count from the capability word |
| cap_gctl_p | input | 1 | Global control word is present |
| gctl | input | 64 | Global control word |
| mce_en | input | 1 | Machine-check handling enabled |
| rep_valid | input | 1 | One-cycle report strobe |
| rep_bank | input | 8 | Target bank of the report |
| rep_status | input | 64 | Reported bank status |
| rep_gstatus | input | 64 | Reported global status |
| rep_addr | input | 64 | Reported address |
| rep_misc | input | 64 | Reported auxiliary word |
| rep_uncond | input | 1 | Log even while a check is in progress |
| wr_en | input | 1 | Register write strobe |
| wr_target | input | 2 | Write target: 0 control, 1 status, 2 global status |
| wr_bank | input | IW | Bank for control/status writes |
| wr_data | input | 64 | Write data |
| rd_bank | input | IW | Bank to read |
| res_valid | output | 1 | Result code valid |
| res_code | output | 2 | 0 logged, 1 ignored, 2 dropped, 3 reset |
| mce_irq | output | 1 | Machine-check interrupt pulse |
| reset_req | output | 1 | Reset request pulse |
| gstat_o | output | 64 | Global status |
| rd_status | output | 64 | Read bank status |
| rd_ctl | output | 64 | Read bank control |
| rd_addr | output | 64 | Read bank address |
| rd_misc | output | 64 | Read bank auxiliary word |

## Verification
A wrong stored valid or uncorrected bit in a bank shows up on the very next report to that bank. It appears as a missing or spurious overflow bit, or as a corrected error overwriting an uncorrected one, visible on a read two cycles later. A corrupted global in-progress bit turns logged reports into ignored ones or reset requests, visible in the result code one cycle after the strobe. The sweep sets up every prior bank state, control setting and in-progress state before each report, so each such fault appears as a wrong code or read value.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  localparam int DW        = 64;
  localparam int SEL_W     = 8;
  localparam int VAL_BIT   = 63;
  localparam int OVF_BIT   = 62;
  localparam int UC_BIT    = 61;
  localparam int AR_BIT    = 55;
  localparam int INPROG_BIT = 2;

  typedef enum logic [1:0] {
    RES_LOGGED  = 2'd0,
    RES_IGNORED = 2'd1,
    RES_DROPPED = 2'd2,
    RES_RESET   = 2'd3
  } res_e;

  typedef enum logic [1:0] {
    WT_CTL    = 2'd0,
    WT_STATUS = 2'd1,
    WT_GSTAT  = 2'd2,
    WT_NONE   = 2'd3
  } wtgt_e;

  typedef struct packed {
    logic          wr_status;
    logic          wr_data;
    logic          wr_gstat;
    logic          irq;
    logic          rst_req;
    res_e          code;
    logic [DW-1:0] new_status;
  } act_t;
endpackage

// File: rtl/mcb_decide.sv
module mcb_decide
  import mcb_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic [SEL_W-1:0] rep_bank,
  input  logic [DW-1:0]    rep_status,
  input  logic             rep_uncond,
  input  logic [7:0]       cap_banks,
  input  logic             cap_gctl_p,
  input  logic [DW-1:0]    gctl,
  input  logic             mce_en,
  input  logic             in_prog,
  input  logic [DW-1:0]    cur_status,
  input  logic [DW-1:0]    cur_ctl,
  output act_t             act
);
  localparam logic [SEL_W-1:0] HW_BANKS = SEL_W'(NUM_BANKS);

  logic bank_ok, is_uc, is_ar, prev_val, prev_uc, uc_blocked;

  assign bank_ok    = (rep_bank < cap_banks) && (rep_bank < HW_BANKS);
  assign is_uc      = rep_status[UC_BIT];
  assign is_ar      = rep_status[AR_BIT];
  assign prev_val   = cur_status[VAL_BIT];
  assign prev_uc    = cur_status[UC_BIT];
  assign uc_blocked = (cap_gctl_p && !(&gctl)) || !(&cur_ctl);

  always_comb begin
    act            = '0;
    act.code       = RES_DROPPED;
    act.new_status = rep_status;
    if (!bank_ok || !rep_status[VAL_BIT]) begin
      act.code = RES_DROPPED;
    end else if (!rep_uncond && !is_ar && in_prog) begin
      act.code = RES_IGNORED;
    end else if (is_uc) begin
      if (uc_blocked) begin
        act.code = RES_DROPPED;
      end else if (!mce_en || in_prog) begin
        act.code    = RES_RESET;
        act.rst_req = 1'b1;
      end else begin
        act.code      = RES_LOGGED;
        act.wr_status = 1'b1;
        act.wr_data   = 1'b1;
        act.wr_gstat  = 1'b1;
        act.irq       = 1'b1;
        act.new_status[OVF_BIT] = rep_status[OVF_BIT] | prev_val;
      end
    end else if (!prev_val || !prev_uc) begin
      act.code      = RES_LOGGED;
      act.wr_status = 1'b1;
      act.wr_data   = 1'b1;
      act.new_status[OVF_BIT] = rep_status[OVF_BIT] | prev_val;
    end else begin
      act.code       = RES_LOGGED;
      act.wr_status  = 1'b1;
      act.new_status = cur_status;
      act.new_status[OVF_BIT] = 1'b1;
    end
  end
endmodule

// File: rtl/mcb_bank_store.sv
module mcb_bank_store
  import mcb_pkg::*;
#(
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] lk_idx,
  output logic [DW-1:0] lk_status,
  output logic [DW-1:0] lk_ctl,
  input  logic          st_we,
  input  logic [IW-1:0] st_idx,
  input  logic [DW-1:0] st_data,
  input  logic          ctl_we,
  input  logic [IW-1:0] ctl_idx,
  input  logic [DW-1:0] ctl_data,
  input  logic          dat_we,
  input  logic [IW-1:0] dat_idx,
  input  logic [DW-1:0] dat_addr,
  input  logic [DW-1:0] dat_misc,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_status,
  output logic [DW-1:0] rd_ctl,
  output logic [DW-1:0] rd_addr,
  output logic [DW-1:0] rd_misc
);
  localparam int DEPTH = 1 << IW;

  logic [DW-1:0] st_q   [DEPTH];
  logic [DW-1:0] ctl_q  [DEPTH];
  logic [DW-1:0] addr_m [DEPTH];
  logic [DW-1:0] misc_m [DEPTH];

  // Status and control need a reset value and a same-cycle lookup: flops.
  for (genvar g = 0; g < DEPTH; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[g]  <= '0;
        ctl_q[g] <= '1;
      end else begin
        if (st_we && st_idx == IW'(g))
          st_q[g] <= st_data;
        if (ctl_we && ctl_idx == IW'(g))
          ctl_q[g] <= ctl_data;
      end
    end
  end

  assign lk_status = st_q[lk_idx];
  assign lk_ctl    = ctl_q[lk_idx];

  // Address and auxiliary words: plain RAM, no reset, registered read.
  always_ff @(posedge clk) begin
    if (dat_we) begin
      addr_m[dat_idx] <= dat_addr;
      misc_m[dat_idx] <= dat_misc;
    end
    rd_addr <= addr_m[rd_idx];
    rd_misc <= misc_m[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_status <= '0;
      rd_ctl    <= '1;
    end else begin
      rd_status <= st_q[rd_idx];
      rd_ctl    <= ctl_q[rd_idx];
    end
  end
endmodule

// File: rtl/mcb_logger.sv
module mcb_logger
  import mcb_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  localparam int IW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       cap_banks,
  input  logic             cap_gctl_p,
  input  logic [DW-1:0]    gctl,
  input  logic             mce_en,
  input  logic             rep_valid,
  input  logic [SEL_W-1:0] rep_bank,
  input  logic [DW-1:0]    rep_status,
  input  logic [DW-1:0]    rep_gstatus,
  input  logic [DW-1:0]    rep_addr,
  input  logic [DW-1:0]    rep_misc,
  input  logic             rep_uncond,
  input  logic             wr_en,
  input  logic [1:0]       wr_target,
  input  logic [IW-1:0]    wr_bank,
  input  logic [DW-1:0]    wr_data,
  input  logic [IW-1:0]    rd_bank,
  output logic             res_valid,
  output logic [1:0]       res_code,
  output logic             mce_irq,
  output logic             reset_req,
  output logic [DW-1:0]    gstat_o,
  output logic [DW-1:0]    rd_status,
  output logic [DW-1:0]    rd_ctl,
  output logic [DW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_misc
);
  logic [IW-1:0] rep_idx;
  logic [DW-1:0] cur_status, cur_ctl;
  act_t          act;
  logic          wr_ok;
  logic          st_we;
  logic [IW-1:0] st_idx;
  logic [DW-1:0] st_data;

  assign rep_idx = rep_bank[IW-1:0];
  assign wr_ok   = wr_en && !rep_valid;

  mcb_decide #(.NUM_BANKS(NUM_BANKS)) u_decide (
    .rep_bank   (rep_bank),
    .rep_status (rep_status),
    .rep_uncond (rep_uncond),
    .cap_banks  (cap_banks),
    .cap_gctl_p (cap_gctl_p),
    .gctl       (gctl),
    .mce_en     (mce_en),
    .in_prog    (gstat_o[INPROG_BIT]),
    .cur_status (cur_status),
    .cur_ctl    (cur_ctl),
    .act        (act)
  );

  assign st_we   = rep_valid ? act.wr_status : (wr_ok && wr_target == WT_STATUS);
  assign st_idx  = rep_valid ? rep_idx : wr_bank;
  assign st_data = rep_valid ? act.new_status : wr_data;

  mcb_bank_store #(.IW(IW)) u_store (
    .clk       (clk),
    .rst       (rst),
    .lk_idx    (rep_idx),
    .lk_status (cur_status),
    .lk_ctl    (cur_ctl),
    .st_we     (st_we),
    .st_idx    (st_idx),
    .st_data   (st_data),
    .ctl_we    (wr_ok && wr_target == WT_CTL),
    .ctl_idx   (wr_bank),
    .ctl_data  (wr_data),
    .dat_we    (rep_valid && act.wr_data),
    .dat_idx   (rep_idx),
    .dat_addr  (rep_addr),
    .dat_misc  (rep_misc),
    .rd_idx    (rd_bank),
    .rd_status (rd_status),
    .rd_ctl    (rd_ctl),
    .rd_addr   (rd_addr),
    .rd_misc   (rd_misc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gstat_o <= '0;
    end else if (rep_valid && act.wr_gstat) begin
      gstat_o <= rep_gstatus;
    end else if (wr_ok && wr_target == WT_GSTAT) begin
      gstat_o <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_code  <= RES_LOGGED;
      mce_irq   <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      res_valid <= rep_valid;
      res_code  <= rep_valid ? act.code : RES_LOGGED;
      mce_irq   <= rep_valid && act.irq;
      reset_req <= rep_valid && act.rst_req;
    end
  end
endmodule

// File: rtl/mcb_logger_chk.sv
module mcb_logger_chk
  import mcb_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          rep_valid,
  input logic [DW-1:0] rep_gstatus,
  input logic          res_valid,
  input logic [1:0]    res_code,
  input logic          mce_irq,
  input logic          reset_req,
  input logic [DW-1:0] gstat_o
);
  assert_result_follows_R8: assert property (@(posedge clk) disable iff (rst)
    rep_valid |=> res_valid);
  assert_result_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !rep_valid |=> !res_valid);
  assert_irq_logged_R5: assert property (@(posedge clk) disable iff (rst)
    mce_irq |-> (res_valid && res_code == RES_LOGGED));
  assert_reset_code_R4: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> (res_valid && res_code == RES_RESET));
  assert_one_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    !(mce_irq && reset_req));
  assert_irq_gstat_R5: assert property (@(posedge clk) disable iff (rst)
    mce_irq |-> gstat_o == $past(rep_gstatus));
  assert_gstat_kept_R2: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_code == RES_IGNORED) |-> gstat_o == $past(gstat_o));
  assert_gstat_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_code == RES_RESET) |-> gstat_o == $past(gstat_o));
endmodule

bind mcb_logger mcb_logger_chk u_chk (.*);

// File: tb/mcb_logger_test.sv
`timescale 1ns/1ps
module mcb_logger_test;
  localparam int NB = 4;
  localparam int IW = 2;
  localparam logic [63:0] V  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] OV = 64'h4000_0000_0000_0000;
  localparam logic [63:0] UC = 64'h2000_0000_0000_0000;
  localparam logic [63:0] AR = 64'h0080_0000_0000_0000;

  logic clk = 0, rst = 1;
  logic [7:0] cap_banks = 8'd3;
  logic cap_gctl_p = 1'b1;
  logic [63:0] gctl = '1;
  logic mce_en = 1'b1;
  logic rep_valid = 0;
  logic [7:0] rep_bank = 0;
  logic [63:0] rep_status = 0, rep_gstatus = 0, rep_addr = 0, rep_misc = 0;
  logic rep_uncond = 0;
  logic wr_en = 0;
  logic [1:0] wr_target = 0;
  logic [IW-1:0] wr_bank = 0, rd_bank = 0;
  logic [63:0] wr_data = 0;
  logic res_valid, mce_irq, reset_req;
  logic [1:0] res_code;
  logic [63:0] gstat_o, rd_status, rd_ctl, rd_addr, rd_misc;

  mcb_logger #(.NUM_BANKS(NB)) uut (.*);

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  logic [63:0] m_st [NB], m_ctl [NB], m_ad [NB], m_mi [NB];
  bit m_known [NB];
  logic [63:0] m_gs;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] t, input int b, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_target = t; wr_bank = b[IW-1:0]; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int b);
    @(negedge clk);
    rd_bank = b[IW-1:0];
    @(negedge clk);
  endtask

  task automatic report(input int b, input logic [63:0] st, input logic [63:0] gs,
                        input logic [63:0] ad, input logic [63:0] mi, input logic un);
    @(negedge clk);
    rep_valid = 1; rep_bank = b[7:0]; rep_status = st; rep_gstatus = gs;
    rep_addr = ad; rep_misc = mi; rep_uncond = un;
    @(negedge clk);
    rep_valid = 0;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int iter = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk("R10 res_valid", 64'(res_valid), 0);
    chk("R10 irq", 64'(mce_irq), 0);
    chk("R10 reset_req", 64'(reset_req), 0);
    chk("R10 gstat", gstat_o, 0);
    for (int b = 0; b < NB; b++) begin
      rd(b);
      chk("R10 status", rd_status, 0);
      chk("R10 ctl", rd_ctl, '1);
      m_st[b] = 0; m_ctl[b] = '1; m_ad[b] = 0; m_mi[b] = 0; m_known[b] = 0;
    end
    m_gs = 0;

    // R9: write collides with report and is discarded
    @(negedge clk);
    rep_valid = 1; rep_bank = 0; rep_status = V | 64'h7; rep_gstatus = 64'h99;
    rep_addr = 64'h100; rep_misc = 64'h200; rep_uncond = 0;
    wr_en = 1; wr_target = 2'd1; wr_bank = 1; wr_data = V | 64'h5;
    @(negedge clk);
    rep_valid = 0; wr_en = 0;
    chk("R6 collide code", 64'(res_code), 0);
    m_st[0] = V | 64'h7; m_ad[0] = 64'h100; m_mi[0] = 64'h200; m_known[0] = 1;
    rd(1);
    chk("R9 discarded write", rd_status, 0);
    rd(0);
    chk("R6 status", rd_status, m_st[0]);
    chk("R6 addr", rd_addr, 64'h100);
    wr(2'd0, 2, 64'h0);
    rd(2);
    chk("R9 ctl write", rd_ctl, 0);
    wr(2'd0, 2, '1);
    wr(2'd3, 2, 64'h0);
    rd(2);
    chk("R9 target none", rd_ctl, '1);

    // Sweep
    for (int b = 0; b < 5; b++)
    for (int p = 0; p < 3; p++)
    for (int ctlok = 0; ctlok < 2; ctlok++)
    for (int gm = 0; gm < 3; gm++)
    for (int rec = 0; rec < 2; rec++)
    for (int me = 0; me < 2; me++)
    for (int vb = 0; vb < 2; vb++)
    for (int uc = 0; uc < 2; uc++)
    for (int ar = 0; ar < 2; ar++)
    for (int un = 0; un < 2; un++) begin
      logic [63:0] pst, st, gs, ad, mi, exp_st;
      logic [1:0] ecode;
      bit inr, gblk, pv, puc, wlog, wdat, wgs;
      string tag;
      iter++;
      pst = (p == 0) ? 64'h0 : (p == 1) ? (V | 64'h11) : (V | UC | 64'h22);
      if (b < NB) begin
        wr(2'd1, b, pst); m_st[b] = pst;
        wr(2'd0, b, ctlok ? '1 : 64'h0); m_ctl[b] = ctlok ? '1 : 64'h0;
      end
      wr(2'd2, 0, rec ? 64'h4 : 64'h0); m_gs = rec ? 64'h4 : 64'h0;
      cap_gctl_p = (gm != 2);
      gctl = (gm == 0) ? '1 : 64'h0000_FFFF_0000_FFFF;
      mce_en = me[0];
      st = (vb ? V : 0) | (uc ? UC : 0) | (ar ? AR : 0) | 64'(iter & 16'hFFFF);
      gs = 64'hA000 + 64'(iter);
      ad = 64'h1_0000_0000 + 64'(iter) * 8;
      mi = ~ad;
      inr = (b < 3);
      gblk = (gm == 1) || !ctlok;
      pv = (b < NB) ? m_st[b][63] : 0;
      puc = (b < NB) ? m_st[b][61] : 0;
      wlog = 0; wdat = 0; wgs = 0;
      exp_st = (b < NB) ? m_st[b] : 0;
      if (!inr || !vb) begin ecode = 2; tag = "R1"; end
      else if (!un && !ar && rec) begin ecode = 1; tag = "R2"; end
      else if (uc) begin
        if (gblk) begin ecode = 2; tag = "R3"; end
        else if (!me || rec) begin ecode = 3; tag = "R4"; end
        else begin
          ecode = 0; tag = "R5"; wlog = 1; wdat = 1; wgs = 1;
          exp_st = st | (pv ? OV : 0);
        end
      end else if (!pv || !puc) begin
        ecode = 0; tag = "R6"; wlog = 1; wdat = 1;
        exp_st = st | (pv ? OV : 0);
      end else begin
        ecode = 0; tag = "R7"; wlog = 1;
        exp_st = m_st[b] | OV;
      end
      report(b, st, gs, ad, mi, un[0]);
      chk({tag, " res_valid R8"}, 64'(res_valid), 1);
      chk({tag, " code"}, 64'(res_code), 64'(ecode));
      chk({tag, " irq"}, 64'(mce_irq), 64'(ecode == 0 && uc == 1));
      chk({tag, " reset_req"}, 64'(reset_req), 64'(ecode == 3));
      @(negedge clk);
      chk("R8 single result", 64'(res_valid), 0);
      if (wlog) m_st[b] = exp_st;
      if (wdat) begin m_ad[b] = ad; m_mi[b] = mi; m_known[b] = 1; end
      if (wgs) m_gs = gs;
      chk({tag, " gstat"}, gstat_o, m_gs);
      if (b < NB) begin
        rd(b);
        chk({tag, " status"}, rd_status, m_st[b]);
        chk({tag, " ctl"}, rd_ctl, m_ctl[b]);
        if (m_known[b]) begin
          chk({tag, " addr"}, rd_addr, m_ad[b]);
          chk({tag, " misc"}, rd_misc, m_mi[b]);
        end
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule